// File: doc/BRIEF.md
# Output Register with Access Watchdog

This block holds a 16-bit register whose bits drive 16 digital output lines. It is guarded by a watchdog that tracks software accesses. A small register bus reaches three registers. The first is the output data register. The second is a control register, which holds the watchdog enable and the interrupt enable. The third is a status register, which holds a sticky timeout flag. The bus has a two-bit address, a read strobe, a write strobe and 16-bit write and read data.

Software keeps the outputs alive by reading or writing the output data register. Either access restarts the watchdog count. If the count runs out while the watchdog is enabled, all lines are forced off and the timeout flag is set. The stored output value is kept. The lines stay off until software writes the output register again, and that write releases the forcing.

The interrupt request is raised while the flag is set, the watchdog is enabled and the interrupt enable is on. The default timeout is 3,999,600 cycles, which is 120 ms at a 33.33 MHz clock.

Top module: `wdog_out_reg`

## Requirements
- R1: While reset is high and after it is released, `out_lines` is 0, `irq` is 0, and all three registers read 0. Reset is synchronous and active high.
- R2: A write to address 0 stores `bus_wdata`. From the next cycle on, bit i of that value drives `out_lines[i]`, with bit 0 driving line 1. A read of address 0 returns the stored value. `bus_rdata` reflects the addressed register combinationally.
- R3: Address 1 is the control register. Bit 3 enables the watchdog and bit 0 enables the interrupt. Both read back as written, and all other bits read 0.
- R4: With the watchdog enabled, suppose no read or write of address 0 happens for TIMEOUT_CYC clock edges. These edges are counted from the last such access, or from the edge that enabled the watchdog. On the next edge, `out_lines` becomes 0 and bit 0 of the status register (address 2) becomes 1.
- R5: A read of address 0 restarts the count, so the expiry moves to TIMEOUT_CYC edges after that read.
- R6: A write of address 0 restarts the count and releases forced-off outputs.
- R7: Reads and writes of addresses 1 and 2 do not restart the count.
- R8: The status flag is sticky. Writing address 2 with bit 0 set clears it. Writing address 2 with bit 0 clear has no effect.
- R9: While the watchdog is disabled, no timeout occurs, the status flag reads 0, and any pending flag is discarded.
- R10: `irq` is 1 exactly when the status flag reads 1 and control bit 0 is 1.
- R11: After a timeout, `out_lines` stays 0 until the next write of address 0. This holds through reads of address 0, which still return the stored value, and through disabling the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register address: 0 output data, 1 control, 2 status |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| out_lines | output | 16 | Digital output lines, with bit 0 driving line 1 |
| irq | output | 1 | Timeout interrupt request |

## Verification
A count that fails to restart on an access shows at the ports as output lines going dark exactly TIMEOUT_CYC edges after an earlier access, rather than after the latest one. The bench samples one cycle before and one cycle after the expected expiry edge, so an off-by-one count is caught in that same cycle. A forcing state that is lost or kept too long shows as `out_lines` disagreeing with the stored register value that address 0 reads back. A flag that is wrong shows both in the status read and on `irq` in the very cycle after the offending edge.

// File: rtl/wor_pkg.sv
package wor_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    // control and status bit positions
    localparam int CTRL_IRQ_EN_BIT = 0;
    localparam int CTRL_WD_EN_BIT  = 3;
    localparam int STAT_TO_BIT     = 0;

    typedef enum logic [ADDR_W-1:0] {
        SEL_OUT  = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic out_wr;
        logic out_rd;
        logic ctrl_wr;
        logic stat_wr;
    } bus_ev_t;

    function automatic logic [DATA_W-1:0] ctrl_image(input logic wd_en, input logic irq_en);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CTRL_WD_EN_BIT]  = wd_en;
        v[CTRL_IRQ_EN_BIT] = irq_en;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] stat_image(input logic flag);
        logic [DATA_W-1:0] v;
        v = '0;
        v[STAT_TO_BIT] = flag;
        return v;
    endfunction

endpackage

// File: rtl/wor_decode.sv
module wor_decode
    import wor_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output bus_ev_t           ev
);
    reg_sel_e sel;

    always_comb begin
        sel        = reg_sel_e'(addr);
        ev         = '0;
        ev.out_wr  = wr && (sel == SEL_OUT);
        ev.out_rd  = rd && (sel == SEL_OUT);
        ev.ctrl_wr = wr && (sel == SEL_CTRL);
        ev.stat_wr = wr && (sel == SEL_STAT);
    end
endmodule

// File: rtl/wor_timer.sv
module wor_timer #(
    parameter int TIMEOUT_CYC = 3_999_600,
    localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             kick,
    output logic             expire,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    assign expire = run && !kick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || kick || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wor_guard.sv
module wor_guard #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              expire,
    output logic [DATA_W-1:0] held,
    output logic              forced,
    output logic [DATA_W-1:0] lines
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= '0;
            forced <= 1'b0;
        end else if (load) begin
            held   <= load_val;
            forced <= 1'b0;
        end else if (expire) begin
            forced <= 1'b1;
        end
    end

    assign lines = forced ? '0 : held;
endmodule

// File: rtl/wor_ctrlstat.sv
module wor_ctrlstat (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic wd_en_in,
    input  logic irq_en_in,
    input  logic stat_wr,
    input  logic clr_in,
    input  logic expire,
    output logic wd_en,
    output logic irq_en,
    output logic flag,
    output logic flag_vis,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wd_en  <= 1'b0;
            irq_en <= 1'b0;
        end else if (ctrl_wr) begin
            wd_en  <= wd_en_in;
            irq_en <= irq_en_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !wd_en) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (stat_wr && clr_in) begin
            flag <= 1'b0;
        end
    end

    assign flag_vis = flag && wd_en;
    assign irq      = flag_vis && irq_en;
endmodule

// File: rtl/wdog_out_reg.sv
module wdog_out_reg
    import wor_pkg::*;
#(
    parameter int TIMEOUT_CYC = 3_999_600,
    localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] out_lines,
    output logic              irq
);
    bus_ev_t           ev;
    logic              kick;
    logic              expire;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] held;
    logic              forced;
    logic              wd_en;
    logic              irq_en;
    logic              flag;
    logic              flag_vis;

    wor_decode u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .ev   (ev)
    );

    assign kick = ev.out_wr || ev.out_rd;

    wor_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .run    (wd_en && !forced),
        .kick   (kick),
        .expire (expire),
        .cnt    (cnt)
    );

    wor_guard #(.DATA_W(DATA_W)) u_grd (
        .clk      (clk),
        .rst      (rst),
        .load     (ev.out_wr),
        .load_val (bus_wdata),
        .expire   (expire),
        .held     (held),
        .forced   (forced),
        .lines    (out_lines)
    );

    wor_ctrlstat u_cs (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ev.ctrl_wr),
        .wd_en_in  (bus_wdata[CTRL_WD_EN_BIT]),
        .irq_en_in (bus_wdata[CTRL_IRQ_EN_BIT]),
        .stat_wr   (ev.stat_wr),
        .clr_in    (bus_wdata[STAT_TO_BIT]),
        .expire    (expire),
        .wd_en     (wd_en),
        .irq_en    (irq_en),
        .flag      (flag),
        .flag_vis  (flag_vis),
        .irq       (irq)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_OUT:  bus_rdata = held;
            SEL_CTRL: bus_rdata = ctrl_image(wd_en, irq_en);
            SEL_STAT: bus_rdata = stat_image(flag_vis);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wor_checker.sv
module wor_checker
    import wor_pkg::*;
#(
    parameter int TIMEOUT_CYC = 3_999_600,
    localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] out_lines,
    input logic              expire,
    input logic              forced,
    input logic              flag,
    input logic              wd_en,
    input logic [CNT_W-1:0]  cnt
);
    // R2
    out_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> (out_lines == $past(bus_wdata)));

    // R11
    forced_dark_chk: assert property (@(posedge clk) disable iff (rst)
        forced |-> (out_lines == '0));

    // R4
    expiry_effect_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (out_lines == '0 && flag));

    // R5
    access_restart_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && bus_addr == 2'd0) |=> (cnt == '0));

    // R9
    disabled_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> !flag);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && wd_en && !(bus_wr && bus_addr == 2'd2 && bus_wdata[STAT_TO_BIT])) |=> flag);
endmodule

bind wdog_out_reg wor_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .out_lines (out_lines),
    .expire    (expire),
    .forced    (forced),
    .flag      (flag),
    .wd_en     (wd_en),
    .cnt       (cnt)
);

// File: tb/tb_wdog_out_reg.sv
module tb_wdog_out_reg;
    localparam int T = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] out_lines;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [15:0] PAT [6] = '{16'h0001, 16'h8000, 16'hFFFF,
                                        16'hAAAA, 16'h5555, 16'h0000};

    always #4 clk = ~clk;

    wdog_out_reg #(.TIMEOUT_CYC(T)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .out_lines (out_lines),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog all-R: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] r;
        idle(3);
        // R1: during reset
        chk("R1 out in reset", out_lines, 16'h0);
        chk("R1 irq in reset", {15'h0, irq}, 16'h0);
        rst = 1'b0;
        idle(1);
        rd(2'd0, r); chk("R1 out reg", r, 16'h0);
        rd(2'd1, r); chk("R1 ctrl reg", r, 16'h0);
        rd(2'd2, r); chk("R1 stat reg", r, 16'h0);

        // R2: pattern table, watchdog off
        foreach (PAT[i]) begin
            wr(2'd0, PAT[i]);
            chk("R2 lines", out_lines, PAT[i]);
            rd(2'd0, r);
            chk("R2 readback", r, PAT[i]);
        end

        // R3
        wr(2'd1, 16'hFFFF);
        rd(2'd1, r); chk("R3 ctrl image", r, 16'h0009);
        wr(2'd1, 16'h0001);
        rd(2'd1, r); chk("R3 irq enable only", r, 16'h0001);
        wr(2'd1, 16'h0000);

        // R9: disabled, no timeout
        wr(2'd0, 16'h00A5);
        idle(3 * T);
        chk("R9 no timeout while off", out_lines, 16'h00A5);
        rd(2'd2, r); chk("R9 stat off", r, 16'h0);

        // R4 / R10: expiry counted from enabling edge
        wr(2'd1, 16'h0009);
        idle(T - 1);
        chk("R4 still on before expiry", out_lines, 16'h00A5);
        chk("R10 irq low before expiry", {15'h0, irq}, 16'h0);
        idle(1);
        chk("R4 off at expiry", out_lines, 16'h0);
        chk("R10 irq at expiry", {15'h0, irq}, 16'h1);
        rd(2'd2, r); chk("R4 stat set", r, 16'h0001);

        // R11: read does not release
        rd(2'd0, r); chk("R11 stored value kept", r, 16'h00A5);
        chk("R11 still dark after read", out_lines, 16'h0);
        // R8
        wr(2'd2, 16'hFFFE);
        rd(2'd2, r); chk("R8 write 0 no effect", r, 16'h0001);
        wr(2'd2, 16'h0001);
        rd(2'd2, r); chk("R8 write 1 clears", r, 16'h0);
        chk("R10 irq after clear", {15'h0, irq}, 16'h0);

        // R6 / R5
        wr(2'd0, 16'h3C3C);
        chk("R6 write releases", out_lines, 16'h3C3C);
        idle(T - 3);
        rd(2'd0, r);
        idle(T - 1);
        chk("R5 read restarted count", out_lines, 16'h3C3C);
        idle(1);
        chk("R5 expiry after read", out_lines, 16'h0);

        // R7
        wr(2'd0, 16'h0F0F);
        rd(2'd1, r);
        wr(2'd2, 16'h0000);
        idle(T - 5);
        chk("R7 on before expiry", out_lines, 16'h0F0F);
        idle(1);
        chk("R7 other regs do not restart", out_lines, 16'h0);

        // R9: disabling discards flag; R11 forcing survives
        wr(2'd1, 16'h0001);
        rd(2'd2, r); chk("R9 stat reads 0 when off", r, 16'h0);
        chk("R9 irq low when off", {15'h0, irq}, 16'h0);
        wr(2'd1, 16'h0009);
        rd(2'd2, r); chk("R9 flag discarded", r, 16'h0);
        chk("R11 dark after disable", out_lines, 16'h0);

        // R10: irq gated by enable bit
        wr(2'd0, 16'h1111);
        wr(2'd1, 16'h0008);
        idle(2 * T);
        rd(2'd2, r); chk("R10 stat set", r, 16'h0001);
        chk("R10 irq masked", {15'h0, irq}, 16'h0);
        wr(2'd1, 16'h0009);
        chk("R10 irq unmasked", {15'h0, irq}, 16'h1);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        chk("R1 irq after reset", {15'h0, irq}, 16'h0);
        chk("R1 lines after reset", out_lines, 16'h0);
        rd(2'd1, r); chk("R1 ctrl after reset", r, 16'h0);

        summary();
        $finish;
    end
endmodule